// File: doc/BRIEF.md
# Vendor Request Register Bridge

This block sits behind a USB device controller that has already parsed the setup stage of each control transfer. The controller hands the bridge a request record (request type, request code and length) followed by the data stage as a stream of bytes. The bridge maps each vendor request onto the registers of a UART-style serial port. These registers are the baud divisor, the line control byte, the modem control byte and a flag that holds transmission back until the far end asserts CTS. Read requests return the line control byte or the modem status byte on an outgoing byte stream. A request the bridge does not recognise is refused with a one-cycle stall pulse.

Separately, on a trigger the bridge takes a snapshot of the modem status and line status bytes and presents them as the two-byte report for the interrupt endpoint. The modem status byte comes first. It also drives a transmit-permission output that combines the CTS gating flag with the live CTS line.

Top module: `vreq_bridge`

## Requirements
- R1: After reset, baud_div is 12, lcr is 0x03 (8 data bits, no parity, 1 stop bit), mcr is 0x00, cts_gate is 0, stall and done are low and req_ready is high.
- R2: A request of type 0x40 with code 0x07 and length 1 writes its data byte to lcr. Code 0x0A with length 1 writes mcr, with bits 7..5 forced to 0.
- R3: Type 0x40 with code 0x05 and length 4 loads baud_div from four data bytes, least significant byte first. baud_div changes only at the clock edge that accepts the fourth byte.
- R4: Type 0x40 with code 0x0C and length 1 sets cts_gate to bit 0 of its data byte. tx_allow is 1 when cts_gate is 0, and otherwise equals msr_in bit 4 (CTS).
- R5: Type 0x40 with code 0x0B and length 1 accepts one data byte, pulses done and leaves every register unchanged.
- R6: Type 0xC0 with length 1 is a read. Code 0x06 returns lcr. Code 0x02 returns msr_in as sampled when the request was accepted. The byte is held on rd_data while rd_valid is high and rd_ready is low.
- R7: An unknown request type, a code that does not belong to the given type, or a length that differs from the one the code needs raises stall for one cycle after acceptance. Such a request changes no register and returns the bridge to idle.
- R8: A pulse on rpt_trig while no report is pending captures msr_in and lsr_in. The bridge then presents the modem status byte first and the line status byte second, each held until rpt_ready. rpt_trig is ignored while a report is pending.
- R9: req_ready is high only when no request is in progress. done pulses for one cycle after the edge that accepts the last data byte of a write, or the edge that hands over the read byte. done and stall are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request record valid |
| req_ready | output | 1 | Bridge idle, accepts a record |
| req_type | input | 8 | Request type byte |
| req_code | input | 8 | Request code byte |
| req_len | input | LEN_W | Data stage length in bytes |
| wr_valid | input | 1 | Host-to-device data byte valid |
| wr_ready | output | 1 | Bridge takes a data byte |
| wr_data | input | 8 | Host-to-device data byte |
| rd_valid | output | 1 | Device-to-host byte valid |
| rd_ready | input | 1 | Device-to-host byte taken |
| rd_data | output | 8 | Device-to-host byte |
| stall | output | 1 | Request refused (one-cycle pulse) |
| done | output | 1 | Request completed (one-cycle pulse) |
| msr_in | input | 8 | Live modem status byte, bit 4 is CTS |
| lsr_in | input | 8 | Live line status byte |
| rpt_trig | input | 1 | Start a status report |
| rpt_valid | output | 1 | Report byte valid |
| rpt_ready | input | 1 | Report byte taken |
| rpt_data | output | 8 | Report byte |
| baud_div | output | 8*DIV_BYTES | Baud divisor |
| lcr | output | 8 | Line control byte |
| mcr | output | 8 | Modem control byte |
| cts_gate | output | 1 | Hold transmission until CTS |
| tx_allow | output | 1 | Transmitter may send |

## Verification
The bench sends a divisor load and compares baud_div between the bytes. A bridge that wrote each byte as it arrived would show a half-updated divisor there. It sends a wrong length, a read code under the write type, an unknown code and a foreign type byte. A decoder that checked only the code would write a register or hang waiting for data instead of stalling. It also changes msr_in after a read request and after a report trigger, and stalls the consumer. A bridge that forwarded live inputs, or restarted the report on a second trigger, would return the new values or the bytes in the wrong order.

// File: rtl/vreq_pkg.sv
package vreq_pkg;
   localparam logic [7:0] RT_SET    = 8'h40;
   localparam logic [7:0] RT_GET    = 8'hC0;
   localparam logic [7:0] RC_DIV    = 8'h05;
   localparam logic [7:0] RC_LCR_RD = 8'h06;
   localparam logic [7:0] RC_LCR_WR = 8'h07;
   localparam logic [7:0] RC_MCR_WR = 8'h0A;
   localparam logic [7:0] RC_MSR_RD = 8'h02;
   localparam logic [7:0] RC_NOP    = 8'h0B;
   localparam logic [7:0] RC_CTS    = 8'h0C;
   localparam int         CTS_BIT   = 4;

   typedef enum logic [2:0] {
      K_BAD, K_DIV, K_LCR, K_MCR, K_CTS, K_NOP, K_RD_LCR, K_RD_MSR
   } kind_t;

   typedef enum logic [1:0] {ST_IDLE, ST_WR, ST_RD} state_t;
endpackage

// File: rtl/vreq_decode.sv
module vreq_decode
   import vreq_pkg::*;
#(
   parameter int LEN_W     = 16,
   parameter int DIV_BYTES = 4
)(
   input  logic [7:0]       req_type,
   input  logic [7:0]       req_code,
   input  logic [LEN_W-1:0] req_len,
   output kind_t            kind,
   output logic             ok,
   output logic             is_get
);
   logic [LEN_W-1:0] want_len;

   always_comb begin
      kind = K_BAD;
      if (req_type == RT_SET) begin
         case (req_code)
            RC_DIV:    kind = K_DIV;
            RC_LCR_WR: kind = K_LCR;
            RC_MCR_WR: kind = K_MCR;
            RC_CTS:    kind = K_CTS;
            RC_NOP:    kind = K_NOP;
            default:   kind = K_BAD;
         endcase
      end else if (req_type == RT_GET) begin
         case (req_code)
            RC_LCR_RD: kind = K_RD_LCR;
            RC_MSR_RD: kind = K_RD_MSR;
            default:   kind = K_BAD;
         endcase
      end
   end

   assign want_len = (kind == K_DIV) ? LEN_W'(DIV_BYTES) : LEN_W'(1);
   assign ok       = (kind != K_BAD) && (req_len == want_len);
   assign is_get   = (kind == K_RD_LCR) || (kind == K_RD_MSR);
endmodule

// File: rtl/vreq_regs.sv
module vreq_regs
   import vreq_pkg::*;
#(
   parameter int                  DIV_BYTES     = 4,
   parameter logic [8*DIV_BYTES-1:0] DIV_RESET  = 12,
   parameter logic [7:0]          LCR_RESET     = 8'h03,
   parameter bit                  MCR_RSVD_ZERO = 1'b1
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     commit,
   input  kind_t                    kind,
   input  logic [8*DIV_BYTES-1:0]   word,
   output logic [8*DIV_BYTES-1:0]   div_q,
   output logic [7:0]               lcr_q,
   output logic [7:0]               mcr_q,
   output logic                     gate_q
);
   logic [7:0] mcr_in;

   generate
      if (MCR_RSVD_ZERO) begin : g_mcr_mask
         assign mcr_in = {3'b000, word[4:0]};
      end else begin : g_mcr_full
         assign mcr_in = word[7:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q  <= DIV_RESET;
         lcr_q  <= LCR_RESET;
         mcr_q  <= 8'h00;
         gate_q <= 1'b0;
      end else if (commit) begin
         case (kind)
            K_DIV:   div_q  <= word;
            K_LCR:   lcr_q  <= word[7:0];
            K_MCR:   mcr_q  <= mcr_in;
            K_CTS:   gate_q <= word[0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/vreq_report.sv
module vreq_report #(
   parameter int BYTE_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rpt_trig,
   input  logic [BYTE_W-1:0] msr_in,
   input  logic [BYTE_W-1:0] lsr_in,
   output logic              rpt_valid,
   input  logic              rpt_ready,
   output logic [BYTE_W-1:0] rpt_data
);
   logic                  busy_q;
   logic                  second_q;
   logic [2*BYTE_W-1:0]   snap_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         second_q <= 1'b0;
         snap_q   <= '0;
      end else if (!busy_q) begin
         if (rpt_trig) begin
            busy_q   <= 1'b1;
            second_q <= 1'b0;
            snap_q   <= {lsr_in, msr_in};
         end
      end else if (rpt_ready) begin
         if (second_q) busy_q <= 1'b0;
         second_q <= ~second_q;
      end
   end

   assign rpt_valid = busy_q;
   assign rpt_data  = second_q ? snap_q[2*BYTE_W-1:BYTE_W] : snap_q[BYTE_W-1:0];

   // R8: a byte offered and not taken stays put
   assert_rpt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rpt_valid && !rpt_ready) |=> (rpt_valid && $stable(rpt_data)));
endmodule

// File: rtl/vreq_bridge.sv
module vreq_bridge
   import vreq_pkg::*;
#(
   parameter int   LEN_W         = 16,
   parameter int   DIV_BYTES     = 4,
   parameter int   DIV_RESET     = 12,
   parameter logic [7:0] LCR_RESET = 8'h03,
   parameter bit   MCR_RSVD_ZERO = 1'b1
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic [7:0]             req_type,
   input  logic [7:0]             req_code,
   input  logic [LEN_W-1:0]       req_len,
   input  logic                   wr_valid,
   output logic                   wr_ready,
   input  logic [7:0]             wr_data,
   output logic                   rd_valid,
   input  logic                   rd_ready,
   output logic [7:0]             rd_data,
   output logic                   stall,
   output logic                   done,
   input  logic [7:0]             msr_in,
   input  logic [7:0]             lsr_in,
   input  logic                   rpt_trig,
   output logic                   rpt_valid,
   input  logic                   rpt_ready,
   output logic [7:0]             rpt_data,
   output logic [8*DIV_BYTES-1:0] baud_div,
   output logic [7:0]             lcr,
   output logic [7:0]             mcr,
   output logic                   cts_gate,
   output logic                   tx_allow
);
   localparam int DIV_W = 8 * DIV_BYTES;
   localparam int CNT_W = $clog2(DIV_BYTES + 1);

   generate
      if (DIV_BYTES < 1 || DIV_BYTES > 8) begin : g_bad_div
         $error("vreq_bridge: DIV_BYTES must lie in 1..8");
      end
      if (LEN_W < CNT_W || LEN_W > 16) begin : g_bad_len
         $error("vreq_bridge: LEN_W out of range");
      end
   endgenerate

   state_t            state_q;
   kind_t             kind_q;
   kind_t             dec_kind;
   logic              dec_ok;
   logic              dec_get;
   logic [CNT_W-1:0]  cnt_q;
   logic [DIV_W-1:0]  stage_q;
   logic [DIV_W-1:0]  word;
   logic [7:0]        rd_q;
   logic              stall_q;
   logic              done_q;
   logic              req_fire;
   logic              wr_fire;
   logic              rd_fire;
   logic              last_byte;
   logic              commit;

   vreq_decode #(.LEN_W(LEN_W), .DIV_BYTES(DIV_BYTES)) decode_i (
      .req_type (req_type),
      .req_code (req_code),
      .req_len  (req_len),
      .kind     (dec_kind),
      .ok       (dec_ok),
      .is_get   (dec_get)
   );

   assign req_ready = (state_q == ST_IDLE);
   assign wr_ready  = (state_q == ST_WR);
   assign rd_valid  = (state_q == ST_RD);
   assign rd_data   = rd_q;
   assign stall     = stall_q;
   assign done      = done_q;

   assign req_fire  = req_valid && req_ready;
   assign wr_fire   = wr_valid && wr_ready;
   assign rd_fire   = rd_valid && rd_ready;
   assign last_byte = (kind_q == K_DIV) ? (cnt_q == CNT_W'(DIV_BYTES - 1)) : 1'b1;
   assign commit    = wr_fire && last_byte;

   always_comb begin
      word = stage_q;
      word[8*int'(cnt_q) +: 8] = wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         kind_q  <= K_BAD;
         cnt_q   <= '0;
         stage_q <= '0;
         rd_q    <= 8'h00;
         stall_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         stall_q <= req_fire && !dec_ok;
         done_q  <= commit || rd_fire;
         case (state_q)
            ST_IDLE: begin
               if (req_fire && dec_ok) begin
                  kind_q  <= dec_kind;
                  cnt_q   <= '0;
                  state_q <= dec_get ? ST_RD : ST_WR;
                  if (dec_get) rd_q <= (dec_kind == K_RD_LCR) ? lcr : msr_in;
               end
            end
            ST_WR: begin
               if (wr_fire) begin
                  stage_q <= word;
                  cnt_q   <= cnt_q + 1'b1;
                  if (last_byte) state_q <= ST_IDLE;
               end
            end
            ST_RD: begin
               if (rd_fire) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   vreq_regs #(
      .DIV_BYTES     (DIV_BYTES),
      .DIV_RESET     (DIV_W'(DIV_RESET)),
      .LCR_RESET     (LCR_RESET),
      .MCR_RSVD_ZERO (MCR_RSVD_ZERO)
   ) regs_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .commit (commit),
      .kind   (kind_q),
      .word   (word),
      .div_q  (baud_div),
      .lcr_q  (lcr),
      .mcr_q  (mcr),
      .gate_q (cts_gate)
   );

   assign tx_allow = !cts_gate || msr_in[CTS_BIT];

   vreq_report #(.BYTE_W(8)) report_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .rpt_trig  (rpt_trig),
      .msr_in    (msr_in),
      .lsr_in    (lsr_in),
      .rpt_valid (rpt_valid),
      .rpt_ready (rpt_ready),
      .rpt_data  (rpt_data)
   );

   // R7: a refused request leaves every register as it was
   assert_stall_keeps_regs_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> ($stable(baud_div) && $stable(lcr) && $stable(mcr) && $stable(cts_gate)));

   // R3: divisor does not move while its bytes are still arriving
   assert_div_atomic_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WR && !commit) |=> $stable(baud_div));

   // R6: read byte is held until taken
   assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

   // R9: completion returns to idle, and never coincides with a stall
   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);
   assert_done_stall_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, stall}));
endmodule

// File: tb/vreq_bridge_tb.sv
module vreq_bridge_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [7:0]  req_type = 8'h00;
   logic [7:0]  req_code = 8'h00;
   logic [15:0] req_len = 16'h0;
   logic        wr_valid = 1'b0;
   logic        wr_ready;
   logic [7:0]  wr_data = 8'h00;
   logic        rd_valid;
   logic        rd_ready = 1'b0;
   logic [7:0]  rd_data;
   logic        stall, done;
   logic [7:0]  msr_in = 8'h00;
   logic [7:0]  lsr_in = 8'h00;
   logic        rpt_trig = 1'b0;
   logic        rpt_valid;
   logic        rpt_ready = 1'b0;
   logic [7:0]  rpt_data;
   logic [31:0] baud_div;
   logic [7:0]  lcr, mcr;
   logic        cts_gate, tx_allow;

   int  checks = 0;
   int  errors = 0;
   bit  finished = 1'b0;

   // reference model state
   logic [31:0] m_div  = 32'd12;
   logic [7:0]  m_lcr  = 8'h03;
   logic [7:0]  m_mcr  = 8'h00;
   logic        m_gate = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vreq_bridge dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_type(req_type), .req_code(req_code), .req_len(req_len),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
      .stall(stall), .done(done),
      .msr_in(msr_in), .lsr_in(lsr_in),
      .rpt_trig(rpt_trig), .rpt_valid(rpt_valid), .rpt_ready(rpt_ready), .rpt_data(rpt_data),
      .baud_div(baud_div), .lcr(lcr), .mcr(mcr), .cts_gate(cts_gate), .tx_allow(tx_allow)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model (R2 R3 R4 R5 R7 registers)
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk({baud_div, lcr, mcr, cts_gate} === {m_div, m_lcr, m_mcr, m_gate},
             "R2/R3/R4 model regs", {baud_div[15:0], lcr, mcr}, {m_div[15:0], m_lcr, m_mcr});
         chk(tx_allow === (!m_gate || msr_in[4]), "R4 tx_allow", 32'(tx_allow),
             32'(!m_gate || msr_in[4]));
      end
   end

   function automatic void model_commit(input logic [7:0] code, input logic [31:0] pl);
      case (code)
         8'h05: m_div  = pl;
         8'h07: m_lcr  = pl[7:0];
         8'h0A: m_mcr  = {3'b000, pl[4:0]};
         8'h0C: m_gate = pl[0];
         default: ;
      endcase
   endfunction

   task automatic set_req(input logic [7:0] typ, input logic [7:0] code, input int len,
                          input logic [31:0] pl, input int nb, input bit exp_stall,
                          input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_type = typ; req_code = code; req_len = 16'(len);
      @(negedge clk);
      req_valid = 1'b0;
      chk(stall === exp_stall, {tag, " stall"}, 32'(stall), 32'(exp_stall));
      if (exp_stall) begin
         chk(req_ready === 1'b1 && lcr === m_lcr && baud_div === m_div, {tag, " R7 idle/unchanged"},
             {23'd0, req_ready, lcr}, {23'd0, 1'b1, m_lcr});
         return;
      end
      for (int i = 0; i < nb; i++) begin
         wr_valid = 1'b1; wr_data = pl[8*i +: 8];
         @(posedge clk);
         #1;
         if (i == nb - 1) model_commit(code, pl);
         @(negedge clk);
         wr_valid = 1'b0;
         if (i < nb - 1 && code == 8'h05)
            chk(baud_div === m_div, "R3 divisor held mid-load", baud_div, m_div);
      end
      chk(done === 1'b1, {tag, " R9 done"}, 32'(done), 32'd1);
   endtask

   task automatic get_req(input logic [7:0] typ, input logic [7:0] code, input int len,
                          input bit exp_stall, input logic [7:0] exp_byte, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_type = typ; req_code = code; req_len = 16'(len);
      @(negedge clk);
      req_valid = 1'b0;
      msr_in = 8'h00;
      chk(stall === exp_stall, {tag, " stall"}, 32'(stall), 32'(exp_stall));
      if (exp_stall) return;
      chk(rd_valid === 1'b1 && rd_data === exp_byte, {tag, " data"}, 32'(rd_data), 32'(exp_byte));
      @(negedge clk);
      chk(rd_valid === 1'b1 && rd_data === exp_byte, {tag, " R6 held"}, 32'(rd_data), 32'(exp_byte));
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
      chk(done === 1'b1 && rd_valid === 1'b0, {tag, " R9 done"}, {30'd0, done, rd_valid}, 32'd2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(baud_div === 32'd12, "R1 divisor", baud_div, 32'd12);
      chk(lcr === 8'h03 && mcr === 8'h00 && cts_gate === 1'b0, "R1 lcr/mcr/gate",
          {15'd0, cts_gate, lcr, mcr}, 32'h0300);
      chk(stall === 1'b0 && done === 1'b0 && req_ready === 1'b1, "R1 handshake",
          {29'd0, stall, done, req_ready}, 32'd1);

      // R2 line and modem control writes
      set_req(8'h40, 8'h07, 1, 32'h1B, 1, 1'b0, "R2 lcr write");
      chk(lcr === 8'h1B, "R2 lcr value", 32'(lcr), 32'h1B);
      set_req(8'h40, 8'h0A, 1, 32'hFF, 1, 1'b0, "R2 mcr write");
      chk(mcr === 8'h1F, "R2 mcr reserved bits", 32'(mcr), 32'h1F);

      // R3 divisor, LSB first
      set_req(8'h40, 8'h05, 4, 32'h0000_0180, 4, 1'b0, "R3 div 384");
      chk(baud_div === 32'h180, "R3 divisor value", baud_div, 32'h180);
      set_req(8'h40, 8'h05, 4, 32'hA1B2_C3D4, 4, 1'b0, "R3 div pattern");
      chk(baud_div === 32'hA1B2_C3D4, "R3 byte order", baud_div, 32'hA1B2_C3D4);

      // R4 CTS gating
      set_req(8'h40, 8'h0C, 1, 32'h01, 1, 1'b0, "R4 gate on");
      chk(cts_gate === 1'b1 && tx_allow === 1'b0, "R4 gated, CTS low",
          {30'd0, cts_gate, tx_allow}, 32'd2);
      msr_in = 8'h10;
      @(negedge clk);
      chk(tx_allow === 1'b1, "R4 gated, CTS high", 32'(tx_allow), 32'd1);
      msr_in = 8'h00;
      set_req(8'h40, 8'h0C, 1, 32'h00, 1, 1'b0, "R4 gate off");
      chk(tx_allow === 1'b1, "R4 ungated", 32'(tx_allow), 32'd1);

      // R5 no-op request
      set_req(8'h40, 8'h0B, 1, 32'h00, 1, 1'b0, "R5 nop");
      chk(lcr === 8'h1B && mcr === 8'h1F && baud_div === 32'hA1B2_C3D4, "R5 no change",
          {16'd0, lcr, mcr}, 32'h1B1F);

      // R6 reads
      get_req(8'hC0, 8'h06, 1, 1'b0, 8'h1B, "R6 lcr read");
      msr_in = 8'h5A;
      get_req(8'hC0, 8'h02, 1, 1'b0, 8'h5A, "R6 msr read");

      // R7 refused requests
      set_req(8'h40, 8'h07, 2, 32'h00, 0, 1'b1, "R7 bad length");
      set_req(8'h40, 8'h06, 1, 32'h00, 0, 1'b1, "R7 get code as set");
      set_req(8'h40, 8'h33, 1, 32'h00, 0, 1'b1, "R7 unknown code");
      set_req(8'h21, 8'h07, 1, 32'h00, 0, 1'b1, "R7 foreign type");
      get_req(8'hC0, 8'h07, 1, 1'b1, 8'h00, "R7 set code as get");
      set_req(8'h40, 8'h05, 1, 32'h00, 0, 1'b1, "R7 short divisor");
      set_req(8'h40, 8'h07, 1, 32'h83, 1, 1'b0, "R7 recovery write");
      chk(lcr === 8'h83, "R7 recovery value", 32'(lcr), 32'h83);

      // R8 status report
      @(negedge clk);
      msr_in = 8'hA5; lsr_in = 8'h61; rpt_trig = 1'b1;
      @(negedge clk);
      rpt_trig = 1'b0;
      chk(rpt_valid === 1'b1 && rpt_data === 8'hA5, "R8 first byte", 32'(rpt_data), 32'hA5);
      msr_in = 8'h00; lsr_in = 8'h00; rpt_trig = 1'b1;
      @(negedge clk);
      rpt_trig = 1'b0;
      chk(rpt_valid === 1'b1 && rpt_data === 8'hA5, "R8 held, retrigger ignored",
          32'(rpt_data), 32'hA5);
      rpt_ready = 1'b1;
      @(negedge clk);
      chk(rpt_valid === 1'b1 && rpt_data === 8'h61, "R8 second byte", 32'(rpt_data), 32'h61);
      @(negedge clk);
      rpt_ready = 1'b0;
      chk(rpt_valid === 1'b0, "R8 report ends", 32'(rpt_valid), 32'd0);

      repeat (2) @(negedge clk);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog R9 actual=hung expected=complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule